// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the address sequence for a synchronous burst memory. A burst starts when either of two active-low address strobes is seen at a rising clock edge. One strobe comes from the processor side and one from the memory-controller side. On that edge the full external address is registered, and its two lowest bits become the start value of a beat counter. After that, each edge that sees the active-low advance input low moves the burst to its next beat. The two low address bits follow either a linear order or an interleaved order, chosen by a static mode input. The upper bits stay fixed for the whole burst.

Three chip enables are sampled on the strobe edge and decide whether the new burst selects the device. The result is held on a valid flag until the next accepted strobe. A source flag reports which strobe started the current burst. It makes the fixed priority between the two strobes visible. The processor strobe is only honoured while the primary chip enable is low.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is all zeros, `valid_o` is 0 and `src_proc_o` is 0.
- R2: On a rising edge where an accepted strobe is present, `addr_i` is registered. From the next cycle, `addr_o` equals that address at beat 0, in both orders.
- R3: If both strobes are low on the same edge while `ce1_ni` is low, only the processor strobe is taken. `src_proc_o` becomes 1, where 1 means processor and 0 means controller.
- R4: A low processor strobe is ignored while `ce1_ni` is high. With the controller strobe high, `addr_o`, `valid_o` and `src_proc_o` do not change on that edge.
- R5: With no accepted strobe and `valid_o` high, `adv_ni` low steps the beat count by one. `adv_ni` high holds `addr_o`.
- R6: With `mode_i` = 0 (linear), `addr_o[1:0]` equals (start + beat) modulo 4.
- R7: With `mode_i` = 1 (interleaved), `addr_o[1:0]` equals start XOR beat.
- R8: `valid_o` takes the value (`ce1_ni`=0 and `ce2_i`=1 and `ce3_ni`=0), sampled on the edge of the accepted strobe. It holds that value until the next accepted strobe.
- R9: The beat after the fourth returns to the first beat of the same sequence. `addr_o` bits above bit 1 never change without an accepted strobe.
- R10: While `valid_o` is 0, a low `adv_ni` does not change `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved (static) |
| addr_i | input | ADDR_W | External start address |
| ads_proc_ni | input | 1 | Processor address strobe, active low |
| ads_ctrl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Advance to next beat, active low |
| ce1_ni | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| addr_o | output | ADDR_W | Current burst address |
| valid_o | output | 1 | Device selected for the current burst |
| src_proc_o | output | 1 | 1 if the processor strobe started the current burst |

## Verification
The bench runs full four-beat bursts from start values 1 and 3 in linear order and from 2 and 3 in interleaved order, then one more advance to check the wrap. A design that mixed up the two orders, carried into bit 2, or reset the start value on wrap would give a wrong low-bit pair there. It drives both strobes together, and the processor strobe alone with the primary enable high. A wrong priority shows as a wrong source flag, and a missing gate shows as a reload. It also loads a deselected burst and then advances it. A design that steps anyway, or takes the valid flag from the wrong enable, shows a changed address or a wrong flag.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    SRC_CTRL = 1'b0,
    SRC_PROC = 1'b1
  } strobe_src_e;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } beat_order_e;
endpackage

// File: rtl/bag_strobe_arb.sv
module bag_strobe_arb
  import burst_pkg::*;
(
  input  logic        ads_proc_ni,
  input  logic        ads_ctrl_ni,
  input  logic        ce1_ni,
  input  logic        ce2_i,
  input  logic        ce3_ni,
  output logic        load_o,
  output strobe_src_e src_o,
  output logic        sel_o
);
  logic proc_ok;

  // processor strobe needs the primary enable; it wins over the controller strobe
  assign proc_ok = ~ads_proc_ni & ~ce1_ni;
  assign load_o  = proc_ok | ~ads_ctrl_ni;
  assign src_o   = proc_ok ? SRC_PROC : SRC_CTRL;
  assign sel_o   = ~ce1_ni & ce2_i & ~ce3_ni;
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] start_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] start_q, beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      beat_q  <= '0;
    end else if (step_i) begin
      beat_q  <= beat_q + 1'b1;  // natural wrap
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  beat_order_e       order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin, ilv;

  assign lin = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_ni,
  input  logic              ads_ctrl_ni,
  input  logic              adv_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              src_proc_o
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic              load, sel, step;
  strobe_src_e       src, src_q;
  logic [UP_W-1:0]   upper_q;
  logic              valid_q;
  logic [BEAT_W-1:0] start_q, beat_q, low;
  beat_order_e       order;

  bag_strobe_arb u_arb (
    .ads_proc_ni (ads_proc_ni),
    .ads_ctrl_ni (ads_ctrl_ni),
    .ce1_ni      (ce1_ni),
    .ce2_i       (ce2_i),
    .ce3_ni      (ce3_ni),
    .load_o      (load),
    .src_o       (src),
    .sel_o       (sel)
  );

  assign step = ~adv_ni & valid_q & ~load;

  bag_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .start_i (addr_i[BEAT_W-1:0]),
    .step_i  (step),
    .start_o (start_q),
    .beat_o  (beat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      valid_q <= 1'b0;
      src_q   <= SRC_CTRL;
    end else if (load) begin
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      valid_q <= sel;
      src_q   <= src;
    end
  end

  assign order = beat_order_e'(mode_i);

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order),
    .start_i (start_q),
    .beat_i  (beat_q),
    .low_o   (low)
  );

  assign addr_o     = {upper_q, low};
  assign valid_o    = valid_q;
  assign src_proc_o = (src_q == SRC_PROC);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ads_proc_ni,
  input logic              ads_ctrl_ni,
  input logic              adv_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              src_proc_o
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (addr_o == '0 && !valid_o && !src_proc_o);
    end
  end

  p_ctrl_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_ctrl_ni) |=> (addr_o == $past(addr_i)));

  p_proc_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && !ce1_ni) |=> src_proc_o);

  p_proc_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && ce1_ni && ads_ctrl_ni && adv_ni) |=>
      ($stable(mode_i) -> ($stable(addr_o) && $stable(valid_o) && $stable(src_proc_o))));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_ni && ads_ctrl_ni && adv_ni) |=>
      ($stable(mode_i) -> ($stable(addr_o) && $stable(valid_o))));

  p_linear_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_ni && ads_ctrl_ni && !adv_ni && valid_o && !mode_i) |=>
      (!mode_i -> (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1))));

  p_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_ctrl_ni || (!ads_proc_ni && !ce1_ni)) |=>
      (valid_o == $past(!ce1_ni && ce2_i && !ce3_ni)));

  p_upper_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_ctrl_ni && (ads_proc_ni || ce1_ni)) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  p_no_step_deselected_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_ni && ads_ctrl_ni && !valid_o) |=>
      ($stable(mode_i) -> $stable(addr_o)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode;
  logic [AW-1:0] addr_in;
  logic          ads_p_n, ads_c_n, adv_n, ce1_n, ce2, ce3_n;
  logic [AW-1:0] addr_out;
  logic          valid, src_p;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .addr_i      (addr_in),
    .ads_proc_ni (ads_p_n),
    .ads_ctrl_ni (ads_c_n),
    .adv_ni      (adv_n),
    .ce1_ni      (ce1_n),
    .ce2_i       (ce2),
    .ce3_ni      (ce3_n),
    .addr_o      (addr_out),
    .valid_o     (valid),
    .src_proc_o  (src_p)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ads_p_n = 1'b1; ads_c_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  // one clock; inputs change and outputs are sampled 1 ns after the edge
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic load_ctrl(input logic [AW-1:0] a);
    addr_in = a; ads_c_n = 1'b0;
    cyc();
    ads_c_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 1'b0; addr_in = '0; idle();
    cyc(); cyc();
    chk("R1 addr", 32'(addr_out), 0);
    chk("R1 valid", 32'(valid), 0);
    chk("R1 src", 32'(src_p), 0);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_load();
    mode = 1'b0;
    load_ctrl(18'h2A5C6);
    chk("R2 ctrl load", 32'(addr_out), 32'h2A5C6);
    chk("R8 valid", 32'(valid), 1);
    chk("R3 ctrl src", 32'(src_p), 0);
    addr_in = 18'h13579; ads_p_n = 1'b0;
    cyc(); ads_p_n = 1'b1;
    chk("R2 proc load", 32'(addr_out), 32'h13579);
    chk("R3 proc src", 32'(src_p), 1);
  endtask

  task automatic t_prio();
    addr_in = 18'h0F0F2; ads_p_n = 1'b0; ads_c_n = 1'b0;
    cyc(); idle();
    chk("R3 both src", 32'(src_p), 1);
    chk("R3 both addr", 32'(addr_out), 32'h0F0F2);
  endtask

  task automatic t_proc_gate();
    load_ctrl(18'h01111);
    addr_in = 18'h3FFFF; ads_p_n = 1'b0; ce1_n = 1'b1;
    cyc(); idle();
    chk("R4 addr kept", 32'(addr_out), 32'h01111);
    chk("R4 src kept", 32'(src_p), 0);
    chk("R4 valid kept", 32'(valid), 1);
    // controller strobe still acts while primary enable is high
    addr_in = 18'h22222; ads_p_n = 1'b0; ads_c_n = 1'b0; ce1_n = 1'b1;
    cyc(); idle();
    chk("R4 ctrl takes over", 32'(addr_out), 32'h22222);
    chk("R8 ce1 high deselects", 32'(valid), 0);
    chk("R3 src ctrl", 32'(src_p), 0);
  endtask

  task automatic run_burst(input string tag, input logic m, input logic [AW-1:0] a,
                           input logic [1:0] exp0, input logic [1:0] exp1,
                           input logic [1:0] exp2, input logic [1:0] exp3);
    logic [1:0] seq [4];
    seq[0] = exp0; seq[1] = exp1; seq[2] = exp2; seq[3] = exp3;
    mode = m;
    load_ctrl(a);
    chk({tag, " beat0"}, 32'(addr_out), 32'({a[AW-1:2], exp0}));
    for (int i = 1; i <= 4; i++) begin
      adv_n = 1'b0;
      cyc();
      adv_n = 1'b1;
      chk({tag, " step"}, 32'(addr_out), 32'({a[AW-1:2], seq[i % 4]}));
    end
  endtask

  task automatic t_orders();
    run_burst("R6 R9 linear s1", 1'b0, 18'h1ABC5, 2'd1, 2'd2, 2'd3, 2'd0);
    run_burst("R6 R9 linear s3", 1'b0, 18'h30003, 2'd3, 2'd0, 2'd1, 2'd2);
    run_burst("R7 R9 ilv s2", 1'b1, 18'h2FFFE, 2'd2, 2'd3, 2'd0, 2'd1);
    run_burst("R7 R9 ilv s3", 1'b1, 18'h04447, 2'd3, 2'd2, 2'd1, 2'd0);
  endtask

  task automatic t_hold();
    mode = 1'b0;
    load_ctrl(18'h15550);
    adv_n = 1'b0; cyc(); adv_n = 1'b1;
    chk("R5 advance", 32'(addr_out), 32'h15551);
    cyc(); cyc();
    chk("R5 hold", 32'(addr_out), 32'h15551);
  endtask

  task automatic t_select();
    ce2 = 1'b0; load_ctrl(18'h00004); idle();
    chk("R8 ce2 low", 32'(valid), 0);
    ce3_n = 1'b1; load_ctrl(18'h00008); idle();
    chk("R8 ce3 high", 32'(valid), 0);
    load_ctrl(18'h0000C);
    chk("R8 all on", 32'(valid), 1);
    ce2 = 1'b0; cyc(); idle();
    chk("R8 held between strobes", 32'(valid), 1);
  endtask

  task automatic t_deselected_adv();
    mode = 1'b0;
    ce3_n = 1'b1; load_ctrl(18'h2D2D1); idle();
    adv_n = 1'b0; cyc(); cyc(); adv_n = 1'b1;
    chk("R10 no step", 32'(addr_out), 32'h2D2D1);
    chk("R10 valid low", 32'(valid), 0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_prio();
    t_proc_gate();
    t_orders();
    t_hold();
    t_select();
    t_deselected_adv();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule